// File: doc/BRIEF.md
# Flash Program/Erase Bus Master

This block sits on the host side of an asynchronous parallel NOR flash bus and carries out one program or erase operation per request. A requester hands over an operation type, a byte address and a data byte through a valid/ready handshake. The controller then drives the unlock and command write cycles using chip-enable, output-enable and write-enable strobes. Each bus phase lasts a parameterised number of clock cycles.

After the last command write, the controller reads the device status until it can decide the outcome. One variant compares status bit 7 against the expected value of the operation. The other variant watches status bit 6 and waits for it to stop alternating between reads. In both variants, bit 5 set to 1 means the device reports that it has run out of time, and the controller must confirm that with extra reads. A read budget guards against a device that never settles. Any failed outcome is followed by a reset command write, so the device returns to read mode. The requester is told the outcome with a single-cycle done pulse and a pass flag.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Operation code 2'b00 (program) produces exactly four writes, in this order: AAh to 555h, 55h to 2AAh, A0h to 555h, then the request data to the request address.
- R2: Operation codes 2'b01 (chip erase) and 2'b10 (sector erase) produce six writes, in this order: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh. The sixth write is 10h@555h for chip erase, or 30h to the request address for sector erase. Code 2'b11 behaves as a sector erase.
- R3: During a write, CE and WE are low and OE is high. The address and data are driven, and stay stable across the falling edge and the rising edge of WE. WE stays low for at least T_WP cycles, and OE and WE are never low together.
- R4: In bit-7 polling mode (POLL_TOGGLE=0), a status read whose bit 7 equals the expected value ends the operation with pass.
- R5: In bit-7 polling mode, a mismatching read with bit 5 = 1 triggers exactly one more read. The result is pass if bit 7 then matches, and fail otherwise.
- R6: In toggle mode (POLL_TOGGLE=1), two successive reads with equal bit 6 end the operation with pass.
- R7: In toggle mode, a read where bit 6 changed and bit 5 = 1 triggers two more reads. The result is fail if bit 6 differs between those two reads, and pass if it is equal.
- R8: For a program, the expected bit 7 is bit 7 of the request data. For either erase, the expected bit 7 is 1.
- R9: Every failed outcome writes F0h to address 0 before done is raised. A passing outcome issues no further write.
- R10: If POLL_LIMIT reads pass without a decision, the operation fails.
- R11: req_ready is high only while the block is idle with the bus released. done is a one-cycle pulse, and done_ok gives the result during that cycle.
- R12: During a read, CE and OE are low, WE is high and the data driver is off. OE returns high between two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_op | input | 2 | 00 program, 01 chip erase, 10/11 sector erase |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | 1 = pass, 0 = fail, valid with done |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Enable for the data bus driver |
| fl_rdata | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The assertions check the strobe rules on every cycle: OE and WE are never low together, WE is only low under CE, the address and data are held around both WE edges, and reads have the driver off. They also check that done lasts one cycle and that the bus is quiet whenever the block is ready. Only the bench scenarios can show the order and content of the command writes, and which status byte patterns end in pass or fail. The same goes for the confirmation reads after bit 5, the read budget, and the reset write that follows a failure in both polling variants.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_CHIP = 2'd1,
      OP_SECT = 2'd2,
      OP_SEC2 = 2'd3
   } fp_op_e;

   typedef enum logic [2:0] {
      BS_IDLE, BS_SETUP, BS_WLOW, BS_WHIGH, BS_RLOW, BS_RHIGH
   } bus_st_e;

   typedef enum logic [2:0] {
      CS_IDLE, CS_CMD, CS_CMD_WT, CS_POLL, CS_POLL_WT, CS_RST, CS_RST_WT, CS_FIN
   } ctl_st_e;

   localparam logic [7:0]  KEY_FIRST  = 8'hAA;
   localparam logic [7:0]  KEY_SECOND = 8'h55;
   localparam logic [7:0]  OPC_PROG   = 8'hA0;
   localparam logic [7:0]  OPC_ERASE  = 8'h80;
   localparam logic [7:0]  OPC_CHIP   = 8'h10;
   localparam logic [7:0]  OPC_SECT   = 8'h30;
   localparam logic [7:0]  OPC_RESET  = 8'hF0;
   localparam logic [11:0] LOC_FIRST  = 12'h555;
   localparam logic [11:0] LOC_SECOND = 12'h2AA;
endpackage

// File: rtl/flash_bus_seq.sv
module flash_bus_seq
   import flash_prog_pkg::*;
#(
   parameter int AW    = 18,
   parameter int T_WP  = 2,
   parameter int T_WPH = 1,
   parameter int T_ACC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_wr,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic          busy,
   output logic          ack,
   output logic [7:0]    rdata,
   output logic [AW-1:0] b_addr,
   output logic [7:0]    b_wdata,
   output logic          b_dq_oe,
   input  logic [7:0]    b_rdata,
   output logic          b_ce_n,
   output logic          b_oe_n,
   output logic          b_we_n
);
   localparam int TSUM = T_WP + T_WPH + T_ACC;
   localparam int CW   = $clog2(TSUM + 1);

   if (T_WP < 1)  $error("T_WP must be at least 1");
   if (T_WPH < 1) $error("T_WPH must be at least 1");
   if (T_ACC < 1) $error("T_ACC must be at least 1");

   bus_st_e       st;
   logic [CW-1:0] cnt;
   logic          last;

   assign last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= BS_IDLE;
         cnt     <= '0;
         ack     <= 1'b0;
         rdata   <= '0;
         b_addr  <= '0;
         b_wdata <= '0;
      end else begin
         ack <= 1'b0;
         case (st)
            BS_IDLE: if (start) begin
               b_addr  <= addr;
               b_wdata <= wdata;
               if (is_wr) begin
                  st <= BS_SETUP;
               end else begin
                  st  <= BS_RLOW;
                  cnt <= CW'(T_ACC - 1);
               end
            end
            BS_SETUP: begin
               st  <= BS_WLOW;
               cnt <= CW'(T_WP - 1);
            end
            BS_WLOW: begin
               if (last) begin
                  st  <= BS_WHIGH;
                  cnt <= CW'(T_WPH - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            BS_RLOW: begin
               if (last) begin
                  rdata <= b_rdata;
                  st    <= BS_RHIGH;
                  cnt   <= CW'(T_WPH - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            BS_WHIGH, BS_RHIGH: begin
               if (last) begin
                  st  <= BS_IDLE;
                  ack <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= BS_IDLE;
         endcase
      end
   end

   assign busy    = (st != BS_IDLE);
   assign b_ce_n  = !((st == BS_SETUP) || (st == BS_WLOW) || (st == BS_RLOW));
   assign b_oe_n  = (st != BS_RLOW);
   assign b_we_n  = (st != BS_WLOW);
   assign b_dq_oe = (st == BS_SETUP) || (st == BS_WLOW) || (st == BS_WHIGH);
endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
   parameter int POLL_TOGGLE = 0,
   parameter int POLL_LIMIT  = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       exp_b7,
   input  logic       rd_ack,
   input  logic [7:0] rd_data,
   output logic       fin,
   output logic       fin_pass
);
   localparam int LW = $clog2(POLL_LIMIT + 1);

   if (POLL_LIMIT < 2) $error("POLL_LIMIT must be at least 2");

   logic [LW-1:0] rd_num;
   logic          limit_hit;
   logic          b7, b6, b5;

   assign limit_hit = (rd_num == LW'(POLL_LIMIT - 1));
   assign b7 = rd_data[7];
   assign b6 = rd_data[6];
   assign b5 = rd_data[5];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_num <= '0;
      else if (start)   rd_num <= '0;
      else if (rd_ack && !limit_hit) rd_num <= rd_num + 1'b1;
   end

   if (POLL_TOGGLE == 0) begin : g_data
      logic confirm, confirm_nx;
      always_comb begin
         fin        = 1'b0;
         fin_pass   = 1'b0;
         confirm_nx = confirm;
         if (rd_ack) begin
            if (confirm) begin
               fin      = 1'b1;
               fin_pass = (b7 == exp_b7);
            end else if (b7 == exp_b7) begin
               fin      = 1'b1;
               fin_pass = 1'b1;
            end else if (b5) begin
               confirm_nx = 1'b1;
            end else if (limit_hit) begin
               fin = 1'b1;
            end
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     confirm <= 1'b0;
         else if (start) confirm <= 1'b0;
         else if (rd_ack) confirm <= confirm_nx;
      end
   end else begin : g_toggle
      logic [1:0] ph, ph_nx;
      logic       prev, have_prev;
      always_comb begin
         fin      = 1'b0;
         fin_pass = 1'b0;
         ph_nx    = ph;
         if (rd_ack) begin
            case (ph)
               2'd0: begin
                  if (have_prev) begin
                     if (b6 == prev) begin
                        fin      = 1'b1;
                        fin_pass = 1'b1;
                     end else if (b5) begin
                        ph_nx = 2'd1;
                     end else if (limit_hit) begin
                        fin = 1'b1;
                     end
                  end
               end
               2'd1: ph_nx = 2'd2;
               default: begin
                  fin      = 1'b1;
                  fin_pass = (b6 == prev);
               end
            endcase
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ph        <= 2'd0;
            prev      <= 1'b0;
            have_prev <= 1'b0;
         end else if (start) begin
            ph        <= 2'd0;
            have_prev <= 1'b0;
         end else if (rd_ack) begin
            ph        <= ph_nx;
            prev      <= b6;
            have_prev <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import flash_prog_pkg::*;
#(
   parameter int AW          = 18,
   parameter int T_WP        = 2,
   parameter int T_WPH       = 1,
   parameter int T_ACC       = 2,
   parameter int POLL_TOGGLE = 0,
   parameter int POLL_LIMIT  = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic          done,
   output logic          done_ok,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_wdata,
   output logic          fl_dq_oe,
   input  logic [7:0]    fl_rdata,
   output logic          fl_ce_n,
   output logic          fl_oe_n,
   output logic          fl_we_n
);
   localparam int ADDR_PAD = AW - 12;

   if (AW < 12) $error("AW must cover the unlock addresses");

   ctl_st_e       st;
   fp_op_e        op_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    data_q;
   logic [2:0]    idx;
   logic [2:0]    last_idx;
   logic          ok_q;

   logic          bs_start, bs_wr, bs_busy, bs_ack;
   logic [AW-1:0] bs_addr;
   logic [7:0]    bs_wdata, bs_rdata;
   logic          ev_start, ev_fin, ev_pass, exp_b7;
   logic [AW+7:0] cmd;

   function automatic logic [AW+7:0] cmd_word(input fp_op_e op, input logic [2:0] i,
                                              input logic [AW-1:0] a, input logic [7:0] d);
      logic [AW-1:0] la, lb;
      la = {{ADDR_PAD{1'b0}}, LOC_FIRST};
      lb = {{ADDR_PAD{1'b0}}, LOC_SECOND};
      case (i)
         3'd0: return {la, KEY_FIRST};
         3'd1: return {lb, KEY_SECOND};
         3'd2: return (op == OP_PROG) ? {la, OPC_PROG} : {la, OPC_ERASE};
         3'd3: return (op == OP_PROG) ? {a, d} : {la, KEY_FIRST};
         3'd4: return {lb, KEY_SECOND};
         default: return (op == OP_CHIP) ? {la, OPC_CHIP} : {a, OPC_SECT};
      endcase
   endfunction

   assign last_idx = (op_q == OP_PROG) ? 3'd3 : 3'd5;
   assign cmd      = cmd_word(op_q, idx, addr_q, data_q);
   assign exp_b7   = (op_q == OP_PROG) ? data_q[7] : 1'b1;

   always_comb begin
      bs_start = 1'b0;
      bs_wr    = 1'b1;
      bs_addr  = cmd[AW+7:8];
      bs_wdata = cmd[7:0];
      case (st)
         CS_CMD:  bs_start = 1'b1;
         CS_POLL: begin
            bs_start = 1'b1;
            bs_wr    = 1'b0;
            bs_addr  = addr_q;
            bs_wdata = '0;
         end
         CS_RST: begin
            bs_start = 1'b1;
            bs_addr  = '0;
            bs_wdata = OPC_RESET;
         end
         default: ;
      endcase
   end

   assign ev_start = (st == CS_CMD_WT) && bs_ack && (idx == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= CS_IDLE;
         op_q   <= OP_PROG;
         addr_q <= '0;
         data_q <= '0;
         idx    <= '0;
         ok_q   <= 1'b0;
      end else begin
         case (st)
            CS_IDLE: if (req_valid) begin
               op_q   <= fp_op_e'(req_op);
               addr_q <= req_addr;
               data_q <= req_data;
               idx    <= '0;
               st     <= CS_CMD;
            end
            CS_CMD:  st <= CS_CMD_WT;
            CS_CMD_WT: if (bs_ack) begin
               if (idx == last_idx) begin
                  st <= CS_POLL;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= CS_CMD;
               end
            end
            CS_POLL: st <= CS_POLL_WT;
            CS_POLL_WT: if (bs_ack) begin
               if (ev_fin && ev_pass) begin
                  ok_q <= 1'b1;
                  st   <= CS_FIN;
               end else if (ev_fin) begin
                  ok_q <= 1'b0;
                  st   <= CS_RST;
               end else begin
                  st <= CS_POLL;
               end
            end
            CS_RST:    st <= CS_RST_WT;
            CS_RST_WT: if (bs_ack) st <= CS_FIN;
            CS_FIN:    st <= CS_IDLE;
            default:   st <= CS_IDLE;
         endcase
      end
   end

   assign req_ready = (st == CS_IDLE);
   assign done      = (st == CS_FIN);
   assign done_ok   = ok_q;

   flash_bus_seq #(.AW(AW), .T_WP(T_WP), .T_WPH(T_WPH), .T_ACC(T_ACC)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (bs_start),
      .is_wr   (bs_wr),
      .addr    (bs_addr),
      .wdata   (bs_wdata),
      .busy    (bs_busy),
      .ack     (bs_ack),
      .rdata   (bs_rdata),
      .b_addr  (fl_addr),
      .b_wdata (fl_wdata),
      .b_dq_oe (fl_dq_oe),
      .b_rdata (fl_rdata),
      .b_ce_n  (fl_ce_n),
      .b_oe_n  (fl_oe_n),
      .b_we_n  (fl_we_n)
   );

   flash_poll_eval #(.POLL_TOGGLE(POLL_TOGGLE), .POLL_LIMIT(POLL_LIMIT)) u_eval (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (ev_start),
      .exp_b7   (exp_b7),
      .rd_ack   (bs_ack && (st == CS_POLL_WT)),
      .rd_data  (bs_rdata),
      .fin      (ev_fin),
      .fin_pass (ev_pass)
   );
endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
   parameter int AW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          done,
   input logic [AW-1:0] fl_addr,
   input logic [7:0]    fl_wdata,
   input logic          fl_dq_oe,
   input logic          fl_ce_n,
   input logic          fl_oe_n,
   input logic          fl_we_n
);
   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_oe_n && !fl_we_n));

   p_we_under_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> !fl_ce_n);

   p_addr_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_we_n) |-> $stable(fl_addr) && $stable(fl_wdata) && fl_dq_oe);

   p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> $stable(fl_addr) && $stable(fl_wdata) && fl_dq_oe);

   p_read_ctrl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> !fl_ce_n && fl_we_n && !fl_dq_oe);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> fl_ce_n && fl_we_n && fl_oe_n);
endmodule

bind flash_prog_ctrl flash_prog_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .done      (done),
   .fl_addr   (fl_addr),
   .fl_wdata  (fl_wdata),
   .fl_dq_oe  (fl_dq_oe),
   .fl_ce_n   (fl_ce_n),
   .fl_oe_n   (fl_oe_n),
   .fl_we_n   (fl_we_n)
);

// File: tb/flash_prog_ctrl_bench.sv
module flash_stub_bfm (
   input  logic        ce_n,
   input  logic        oe_n,
   input  logic        we_n,
   input  logic [17:0] addr,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata
);
   logic [17:0] wr_addr [64];
   logic [7:0]  wr_data [64];
   logic [7:0]  script  [64];
   int          wr_cnt = 0;
   int          rd_cnt = 0;

   always @(posedge we_n) begin
      if (wr_cnt < 64) begin
         wr_addr[wr_cnt] = addr;
         wr_data[wr_cnt] = wdata;
      end
      wr_cnt = wr_cnt + 1;
   end

   always @(posedge oe_n) rd_cnt = rd_cnt + 1;

   assign rdata = (rd_cnt < 64) ? script[rd_cnt] : 8'h00;
endmodule

module flash_prog_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;

   logic        va [2];
   logic [1:0]  opv [2];
   logic [17:0] adv [2];
   logic [7:0]  dav [2];
   logic        rdy [2];
   logic        dn [2];
   logic        ok [2];
   logic [17:0] fa [2];
   logic [7:0]  fw [2];
   logic [7:0]  fr [2];
   logic        fdq [2], fce [2], foe [2], fwe [2];

   flash_prog_ctrl #(.AW(18), .T_WP(2), .T_WPH(1), .T_ACC(2), .POLL_TOGGLE(0), .POLL_LIMIT(6))
   u_flash_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(va[0]), .req_ready(rdy[0]), .req_op(opv[0]),
      .req_addr(adv[0]), .req_data(dav[0]), .done(dn[0]), .done_ok(ok[0]),
      .fl_addr(fa[0]), .fl_wdata(fw[0]), .fl_dq_oe(fdq[0]), .fl_rdata(fr[0]),
      .fl_ce_n(fce[0]), .fl_oe_n(foe[0]), .fl_we_n(fwe[0]));

   flash_prog_ctrl #(.AW(18), .T_WP(2), .T_WPH(1), .T_ACC(2), .POLL_TOGGLE(1), .POLL_LIMIT(6))
   u_flash_prog_ctrl_tog (
      .clk(clk), .rst_n(rst_n), .req_valid(va[1]), .req_ready(rdy[1]), .req_op(opv[1]),
      .req_addr(adv[1]), .req_data(dav[1]), .done(dn[1]), .done_ok(ok[1]),
      .fl_addr(fa[1]), .fl_wdata(fw[1]), .fl_dq_oe(fdq[1]), .fl_rdata(fr[1]),
      .fl_ce_n(fce[1]), .fl_oe_n(foe[1]), .fl_we_n(fwe[1]));

   flash_stub_bfm u_dev0 (.ce_n(fce[0]), .oe_n(foe[0]), .we_n(fwe[0]), .addr(fa[0]),
                          .wdata(fw[0]), .rdata(fr[0]));
   flash_stub_bfm u_dev1 (.ce_n(fce[1]), .oe_n(foe[1]), .we_n(fwe[1]), .addr(fa[1]),
                          .wdata(fw[1]), .rdata(fr[1]));

   int wbase, rbase;

   task automatic check(input bit cond, input string tag, input int act, input int exp);
      n_checks++;
      if (!cond) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int wcnt(input int w);
      return (w == 0) ? u_dev0.wr_cnt : u_dev1.wr_cnt;
   endfunction
   function automatic int rcnt(input int w);
      return (w == 0) ? u_dev0.rd_cnt : u_dev1.rd_cnt;
   endfunction

   task automatic set_script(input int w, input int k, input logic [7:0] v);
      if (w == 0) u_dev0.script[u_dev0.rd_cnt + k] = v;
      else        u_dev1.script[u_dev1.rd_cnt + k] = v;
   endtask

   task automatic exp_wr(input int w, input int k, input logic [17:0] a,
                         input logic [7:0] d, input string tag);
      logic [17:0] ga;
      logic [7:0]  gd;
      ga = (w == 0) ? u_dev0.wr_addr[wbase + k] : u_dev1.wr_addr[wbase + k];
      gd = (w == 0) ? u_dev0.wr_data[wbase + k] : u_dev1.wr_data[wbase + k];
      check(ga == a && gd == d, tag, {ga, gd}, {a, d});
   endtask

   task automatic run_op(input int w, input logic [1:0] op, input logic [17:0] a,
                         input logic [7:0] d, output logic res);
      int cyc;
      wbase = wcnt(w);
      rbase = rcnt(w);
      @(negedge clk);
      va[w] = 1'b1; opv[w] = op; adv[w] = a; dav[w] = d;
      @(negedge clk);
      va[w] = 1'b0;
      check(rdy[w] == 1'b0, "R11 ready low while busy", rdy[w], 0);
      cyc = 0;
      while (dn[w] !== 1'b1 && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      check(cyc < 2000, "R11 done within bound", cyc, 2000);
      res = ok[w];
      @(negedge clk);
      check(dn[w] == 1'b0, "R11 done single cycle", dn[w], 0);
      check(rdy[w] == 1'b1 && fce[w] == 1'b1, "R11 ready after done", rdy[w], 1);
   endtask

   task automatic prog_seq(input int w, input logic [17:0] a, input logic [7:0] d);
      exp_wr(w, 0, 18'h555, 8'hAA, "R1 unlock1");
      exp_wr(w, 1, 18'h2AA, 8'h55, "R1 unlock2");
      exp_wr(w, 2, 18'h555, 8'hA0, "R1 setup");
      exp_wr(w, 3, a, d, "R1 target");
   endtask

   task automatic erase_seq(input int w, input logic [17:0] a6, input logic [7:0] d6);
      exp_wr(w, 0, 18'h555, 8'hAA, "R2 w1");
      exp_wr(w, 1, 18'h2AA, 8'h55, "R2 w2");
      exp_wr(w, 2, 18'h555, 8'h80, "R2 w3");
      exp_wr(w, 3, 18'h555, 8'hAA, "R2 w4");
      exp_wr(w, 4, 18'h2AA, 8'h55, "R2 w5");
      exp_wr(w, 5, a6, d6, "R2 w6");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      logic r;
      for (int w = 0; w < 2; w++) begin
         va[w] = 0; opv[w] = 0; adv[w] = 0; dav[w] = 0;
      end
      for (int k = 0; k < 64; k++) begin
         u_dev0.script[k] = 8'h00;
         u_dev1.script[k] = 8'h00;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int w = 0; w < 2; w++) begin
         check(rdy[w] == 1 && dn[w] == 0, "R11 reset ready", rdy[w], 1);
         check(fce[w] && foe[w] && fwe[w], "R3 reset strobes idle", {fce[w], foe[w], fwe[w]}, 7);
      end

      // R4 R1: bit 7 mismatch then match
      set_script(0, 0, 8'h25); set_script(0, 1, 8'hA5);
      run_op(0, 2'b00, 18'h12345, 8'hA5, r);
      check(r == 1, "R4 program pass", r, 1);
      check(wcnt(0) - wbase == 4, "R1 write count", wcnt(0) - wbase, 4);
      prog_seq(0, 18'h12345, 8'hA5);
      check(rcnt(0) - rbase == 2, "R4 read count", rcnt(0) - rbase, 2);

      // R5 R8: bit 5 set, confirm read matches (expected bit 7 = 0)
      set_script(0, 0, 8'hA0); set_script(0, 1, 8'h3C);
      run_op(0, 2'b00, 18'h00010, 8'h3C, r);
      check(r == 1, "R5 reread pass", r, 1);
      check(rcnt(0) - rbase == 2, "R5 one extra read", rcnt(0) - rbase, 2);
      check(wcnt(0) - wbase == 4, "R9 no reset on pass", wcnt(0) - wbase, 4);

      // R5 R9: bit 5 set, confirm mismatch
      set_script(0, 0, 8'h20); set_script(0, 1, 8'h20);
      run_op(0, 2'b00, 18'h00020, 8'h81, r);
      check(r == 0, "R5 reread fail", r, 0);
      check(wcnt(0) - wbase == 5, "R9 reset write count", wcnt(0) - wbase, 5);
      exp_wr(0, 4, 18'h0, 8'hF0, "R9 reset write");

      // R2 R8: chip erase
      set_script(0, 0, 8'h00); set_script(0, 1, 8'h00); set_script(0, 2, 8'h80);
      run_op(0, 2'b01, 18'h1F0F0, 8'h00, r);
      check(r == 1, "R8 chip erase pass", r, 1);
      check(rcnt(0) - rbase == 3, "R8 erase reads", rcnt(0) - rbase, 3);
      erase_seq(0, 18'h555, 8'h10);

      // R2: sector erase
      set_script(0, 0, 8'h80);
      run_op(0, 2'b10, 18'h2ABCD, 8'h00, r);
      check(r == 1, "R2 sector erase pass", r, 1);
      erase_seq(0, 18'h2ABCD, 8'h30);

      // R2: code 11 acts as sector erase
      set_script(0, 0, 8'hFF);
      run_op(0, 2'b11, 18'h31000, 8'h00, r);
      check(r == 1, "R2 code 11 pass", r, 1);
      erase_seq(0, 18'h31000, 8'h30);

      // R10: read budget
      run_op(0, 2'b00, 18'h3FFFF, 8'hFF, r);
      check(r == 0, "R10 limit fail", r, 0);
      check(rcnt(0) - rbase == 6, "R10 read budget", rcnt(0) - rbase, 6);
      exp_wr(0, 4, 18'h0, 8'hF0, "R9 reset after limit");

      // R6: toggle settles
      set_script(1, 0, 8'h40); set_script(1, 1, 8'h00); set_script(1, 2, 8'h00);
      run_op(1, 2'b00, 18'h00100, 8'h11, r);
      check(r == 1, "R6 toggle stop pass", r, 1);
      check(rcnt(1) - rbase == 3, "R6 read count", rcnt(1) - rbase, 3);
      prog_seq(1, 18'h00100, 8'h11);

      // R7: still toggling after bit 5
      set_script(1, 0, 8'h40); set_script(1, 1, 8'h20);
      set_script(1, 2, 8'h40); set_script(1, 3, 8'h00);
      run_op(1, 2'b00, 18'h00200, 8'h22, r);
      check(r == 0, "R7 toggle fail", r, 0);
      check(rcnt(1) - rbase == 4, "R7 two more reads", rcnt(1) - rbase, 4);
      exp_wr(1, 4, 18'h0, 8'hF0, "R9 toggle reset write");

      // R7: settled during confirm reads
      set_script(1, 0, 8'h40); set_script(1, 1, 8'h20);
      set_script(1, 2, 8'h00); set_script(1, 3, 8'h00);
      run_op(1, 2'b10, 18'h10000, 8'h00, r);
      check(r == 1, "R7 toggle confirm pass", r, 1);
      check(wcnt(1) - wbase == 6, "R9 no reset toggle pass", wcnt(1) - wbase, 6);

      // R10: toggle never settles
      for (int k = 0; k < 6; k++) set_script(1, k, (k % 2 == 0) ? 8'h40 : 8'h00);
      run_op(1, 2'b00, 18'h00300, 8'h33, r);
      check(r == 0, "R10 toggle limit fail", r, 0);
      check(rcnt(1) - rbase == 6, "R10 toggle read budget", rcnt(1) - rbase, 6);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule